// File: doc/BRIEF.md
# Two-Register I2C Control Target with High-Speed Entry

This block is the serial control port of a boost-converter controller. It watches an already synchronised and filtered SCL/SDA pair, answers to 7-bit address 0x60, and keeps two 8-bit control registers. Every field of those registers goes straight to the converter logic as a port. A power-good level from the converter can be read back through the bus. The block pulls SDA low through an open-drain enable (`sda_pull` high means the line is pulled low). It never drives the line high.

A write is START, address with W, register pointer, one data byte, STOP. A read sets the pointer the same way, then sends a repeated START and the address with R, and the target returns one byte. A master code of the form 0000_1xxx after a START is not acknowledged. It puts the port in high-speed mode, which survives repeated STARTs and ends at the next STOP. While the external enable is low the port ignores the bus. Each rising edge of that enable reloads both registers with their defaults.

Top module: `i2c_ctrl_target`

## Requirements
- R1: After reset, register 0 reads 0x2D and register 1 reads 0x17, with power-good supplied in bit 7 of register 1 on reads. The field outputs match these values.
- R2: The target acknowledges only an address byte whose upper seven bits are 0x60. Any other address (except a master code) is not acknowledged and leaves every register unchanged.
- R3: Register 0 holds vout_code in bits 2:0, ripple_code in bits 4:3, bal_on in bit 5 and force_pwm in bit 6. Bit 7 is reserved: writes to it are ignored and it reads 0. A written byte appears on the field outputs by the time the data byte's acknowledge completes.
- R4: Register 1 holds ilim_code in bits 2:0, balmode in bit 3, conv_en in bit 4 and ton_code in bits 6:5. Bit 7 reads the pgood input at the moment the read starts and is never stored, so writes to it are ignored.
- R5: A read returns the addressed register MSB first. The target changes SDA only while SCL is low, then releases SDA for the master's acknowledge.
- R6: A register pointer other than 0x00 or 0x01 is acknowledged, its write data is acknowledged and discarded, and a read from it returns 0x00.
- R7: A first byte of 0000_1xxx after a START is not acknowledged and sets hs_mode. hs_mode stays set across repeated STARTs and clears on any STOP.
- R8: While enable_in is low the target never pulls SDA and no bus traffic changes any register.
- R9: Every rising edge of enable_in reloads both registers with the R1 defaults.
- R10: A START or STOP that arrives before the eighth bit of a data byte aborts the transfer and leaves every register unchanged.
- R11: A repeated START behaves exactly as a first START, so a complete write that follows a repeated START takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_in | input | 1 | Converter enable; low ignores the bus, a rising edge reloads defaults |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level (wired bus value) |
| pgood_in | input | 1 | Power-good status, read back as bit 7 of register 1 |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| hs_mode | output | 1 | High-speed mode flag |
| vout_code | output | 3 | Output-voltage select |
| ripple_code | output | 2 | Light-load ripple select |
| bal_on | output | 1 | Balancing circuit on while enabled |
| force_pwm | output | 1 | 1 forces PWM, 0 selects automatic mode |
| ton_code | output | 2 | Soft-start time select |
| ilim_code | output | 3 | Switch current-limit select |
| balmode | output | 1 | Balancing kept on while disabled |
| conv_en | output | 1 | Converter enable field |

## Verification
The assertions assume that scl_in and sda_in are already free of glitches and stay stable for at least one clock between transitions. They also assume that the master moves SDA only while SCL is low, except when it deliberately signals START or STOP. The stimulus holds each half of every bit for four clocks and changes its own SDA level only after SCL has been low for that time. So every edge the port decodes is the one the bench intended. Random transfers mix pointer values inside and outside the map, random data and random power-good levels, and the bench checks them against a reference model of both registers.

// File: rtl/i2c_ctrl_target.sv
module i2c_ctrl_target #(
  parameter logic [6:0] DEV_ADDR  = 7'h60,
  parameter logic [4:0] HS_PREFIX = 5'b00001,
  parameter logic [7:0] REG0_INIT = 8'h2D,
  parameter logic [7:0] REG1_INIT = 8'h17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable_in,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       pgood_in,
  output logic       sda_pull,
  output logic       hs_mode,
  output logic [2:0] vout_code,
  output logic [1:0] ripple_code,
  output logic       bal_on,
  output logic       force_pwm,
  output logic [1:0] ton_code,
  output logic [2:0] ilim_code,
  output logic       balmode,
  output logic       conv_en
);

  typedef enum logic [2:0] {P_IDLE, P_ADDR, P_REG, P_WDATA, P_RDATA, P_SKIP} phase_t;

  phase_t     ph;
  logic       scl_q, sda_q, en_q, rw_q, ack_pend;
  logic [3:0] bitcnt;
  logic [7:0] sreg, ptr, rbyte, reg0, reg1;

  wire        act       = enable_in & en_q;
  wire        start_det = scl_in & scl_q & sda_q & ~sda_in;
  wire        stop_det  = scl_in & scl_q & ~sda_q & sda_in;
  wire        scl_rise  = scl_in & ~scl_q;
  wire        scl_fall  = ~scl_in & scl_q;
  wire [7:0]  nxt_byte  = {sreg[6:0], sda_in};
  wire        byte_done = act & ~start_det & ~stop_det & (ph != P_IDLE) & scl_rise & (bitcnt == 4'd7);
  wire        wr_stb    = byte_done & (ph == P_WDATA);
  wire [7:0]  rd_val    = (ptr == 8'h00) ? reg0 :
                          (ptr == 8'h01) ? {pgood_in, reg1[6:0]} : 8'h00;
  wire [2:0]  tx_idx    = 3'd7 - bitcnt[2:0];

  assign vout_code   = reg0[2:0];
  assign ripple_code = reg0[4:3];
  assign bal_on      = reg0[5];
  assign force_pwm   = reg0[6];
  assign ilim_code   = reg1[2:0];
  assign balmode     = reg1[3];
  assign conv_en     = reg1[4];
  assign ton_code    = reg1[6:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      en_q     <= 1'b0;
      ph       <= P_IDLE;
      bitcnt   <= '0;
      sreg     <= '0;
      ptr      <= '0;
      rbyte    <= '0;
      rw_q     <= 1'b0;
      ack_pend <= 1'b0;
      sda_pull <= 1'b0;
      hs_mode  <= 1'b0;
      reg0     <= REG0_INIT;
      reg1     <= REG1_INIT;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      en_q  <= enable_in;
      if (enable_in && !en_q) begin
        reg0 <= REG0_INIT;
        reg1 <= REG1_INIT;
      end
      if (!act) begin
        ph       <= P_IDLE;
        bitcnt   <= '0;
        ack_pend <= 1'b0;
        sda_pull <= 1'b0;
        hs_mode  <= 1'b0;
      end else if (start_det) begin
        ph       <= P_ADDR;
        bitcnt   <= '0;
        ack_pend <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        ph       <= P_IDLE;
        bitcnt   <= '0;
        ack_pend <= 1'b0;
        sda_pull <= 1'b0;
        hs_mode  <= 1'b0;
      end else if (ph != P_IDLE && scl_rise) begin
        if (bitcnt != 4'd8) begin
          sreg   <= nxt_byte;
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == 4'd7) begin
            case (ph)
              P_ADDR: begin
                if (nxt_byte[7:1] == DEV_ADDR) begin
                  ack_pend <= 1'b1;
                  rw_q     <= nxt_byte[0];
                end else begin
                  if (nxt_byte[7:3] == HS_PREFIX) hs_mode <= 1'b1;
                  ph <= P_SKIP;
                end
              end
              P_REG: begin
                ptr      <= nxt_byte;
                ack_pend <= 1'b1;
              end
              P_WDATA: begin
                ack_pend <= 1'b1;
                if (ptr == 8'h00) reg0 <= {1'b0, nxt_byte[6:0]};
                else if (ptr == 8'h01) reg1 <= {1'b0, nxt_byte[6:0]};
              end
              default: ;
            endcase
          end
        end else begin
          bitcnt   <= '0;
          ack_pend <= 1'b0;
          case (ph)
            P_ADDR: begin
              ph    <= rw_q ? P_RDATA : P_REG;
              rbyte <= rd_val;
            end
            P_REG:   ph <= P_WDATA;
            default: ph <= P_SKIP;
          endcase
        end
      end else if (ph != P_IDLE && scl_fall) begin
        sda_pull <= (bitcnt == 4'd8 && ack_pend) ||
                    (ph == P_RDATA && bitcnt != 4'd8 && !rbyte[tx_idx]);
      end
    end
  end

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_in |=> !sda_pull); // R8

  AST_DEFAULTS_ON_EN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_in && !en_q) |=> (reg0 == REG0_INIT && reg1 == REG1_INIT)); // R9

  AST_HS_CLEAR_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !hs_mode); // R7

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !(enable_in && !en_q)) |=> ($stable(reg0) && $stable(reg1))); // R10

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == P_IDLE) |-> !sda_pull); // R5

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg0[7] && !reg1[7])); // R4

endmodule

// File: tb/i2c_ctrl_target_tb.sv
module i2c_ctrl_target_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0, en_tb = 1'b1, pg = 1'b1, sda_m = 1'b1, scl_m = 1'b1;
  logic sda_pull, hs_mode, bal_on, force_pwm, balmode, conv_en;
  logic [2:0] vout_code, ilim_code;
  logic [1:0] ripple_code, ton_code;
  wire sda_line = sda_m & ~sda_pull;
  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [7:0] m0 = 8'h2D, m1 = 8'h17;

  always #5 clk = ~clk;

  i2c_ctrl_target u_dut (
    .clk(clk), .rst_n(rst_n), .enable_in(en_tb), .scl_in(scl_m), .sda_in(sda_line),
    .pgood_in(pg), .sda_pull(sda_pull), .hs_mode(hs_mode), .vout_code(vout_code),
    .ripple_code(ripple_code), .bal_on(bal_on), .force_pwm(force_pwm), .ton_code(ton_code),
    .ilim_code(ilim_code), .balmode(balmode), .conv_en(conv_en));

  function automatic logic [7:0] exp_rd(input logic [7:0] a, input logic p);
    if (a == 8'h00) return m0;
    if (a == 8'h01) return {p, m1[6:0]};
    return 8'h00;
  endfunction

  function automatic void model_wr(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h00) m0 = {1'b0, d[6:0]};
    else if (a == 8'h01) m1 = {1'b0, d[6:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_fields(input string tag);
    logic [15:0] act, exp;
    act = {1'b0, force_pwm, bal_on, ripple_code, vout_code, 1'b0, ton_code, conv_en, balmode, ilim_code};
    exp = {m0, m1};
    chk(act == exp, tag, act, exp);
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic bit_clk(input logic v, output logic s);
    sda_m = v; half();
    scl_m = 1'b1; half();
    s = sda_line;
    scl_m = 1'b0;
  endtask

  task automatic start_c();
    sda_m = 1'b1; half();
    scl_m = 1'b1; half();
    sda_m = 1'b0; half();
    scl_m = 1'b0; half();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; half();
    scl_m = 1'b1; half();
    sda_m = 1'b1; half(); half();
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_clk(b[i], s);
    bit_clk(1'b1, s);
    ack = ~s;
    sda_m = 1'b1;
  endtask

  task automatic recv(output logic [7:0] b, input logic mack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_clk(1'b1, s);
      b[i] = s;
    end
    bit_clk(~mack, s);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, output logic [2:0] acks);
    start_c();
    send(8'hC0, acks[2]); send(a, acks[1]); send(d, acks[0]);
    stop_c();
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d, output logic [2:0] acks);
    start_c();
    send(8'hC0, acks[2]); send(a, acks[1]);
    start_c();
    send(8'hC1, acks[0]);
    recv(d, 1'b1);
    stop_c();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [2:0] ak;
    logic [7:0] rd;
    logic a1, s;
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    half();

    // R1 reset state
    chk_fields("R1 fields after reset");
    chk(sda_pull == 1'b0 && hs_mode == 1'b0, "R1 idle outputs", {sda_pull, hs_mode}, 0);
    do_read(8'h00, rd, ak);
    chk(rd == 8'h2D && ak == 3'b111, "R1 read reg0", {ak, rd}, {3'b111, 8'h2D});
    pg = 1'b1;
    do_read(8'h01, rd, ak);
    chk(rd == 8'h97, "R1 read reg1 pgood=1", rd, 8'h97);
    pg = 1'b0;
    do_read(8'h01, rd, ak);
    chk(rd == 8'h17, "R1 read reg1 pgood=0", rd, 8'h17);

    // R2 foreign address
    do_write(8'h00, 8'h00, ak);
    start_c(); send(8'hA2, a1); send(8'h00, s); send(8'h00, s); stop_c();
    model_wr(8'h00, 8'h00);
    chk(a1 == 1'b0, "R2 foreign address not acked", a1, 0);
    chk_fields("R2 registers unchanged");

    // R3 register 0 layout, reserved bit
    do_write(8'h00, 8'hFF, ak);
    model_wr(8'h00, 8'hFF);
    chk(ak == 3'b111, "R3 write acks", ak, 3'b111);
    chk_fields("R3 fields after write 0xFF");
    do_read(8'h00, rd, ak);
    chk(rd == 8'h7F, "R3 reserved bit reads 0", rd, 8'h7F);

    // R4 register 1 layout, pgood read only
    do_write(8'h01, 8'hEA, ak);
    model_wr(8'h01, 8'hEA);
    chk_fields("R4 fields after write");
    pg = 1'b0;
    do_read(8'h01, rd, ak);
    chk(rd == 8'h6A, "R4 pgood not stored", rd, 8'h6A);

    // R5 MSB-first read with alternating pattern
    do_write(8'h00, 8'h55, ak);
    model_wr(8'h00, 8'h55);
    do_read(8'h00, rd, ak);
    chk(rd == 8'h55, "R5 read bit order", rd, 8'h55);
    chk(sda_pull == 1'b0, "R5 line released after read", sda_pull, 0);

    // R6 unmapped pointer
    do_write(8'h05, 8'h12, ak);
    chk(ak == 3'b111, "R6 unmapped write acked", ak, 3'b111);
    chk_fields("R6 unmapped write discarded");
    do_read(8'h05, rd, ak);
    chk(rd == 8'h00 && ak == 3'b111, "R6 unmapped read", {ak, rd}, {3'b111, 8'h00});

    // R7 high-speed entry, kept over repeated START, cleared by STOP
    start_c(); send(8'h0B, a1);
    chk(a1 == 1'b0, "R7 master code not acked", a1, 0);
    chk(hs_mode == 1'b1, "R7 hs set", hs_mode, 1);
    start_c(); send(8'hC0, s); send(8'h00, s); send(8'h21, s);
    model_wr(8'h00, 8'h21);
    chk(hs_mode == 1'b1, "R7 hs kept over repeated start", hs_mode, 1);
    chk_fields("R11 write after repeated start");
    stop_c();
    chk(hs_mode == 1'b0, "R7 hs cleared by stop", hs_mode, 0);

    // R10 abort mid data byte by STOP
    start_c(); send(8'hC0, s); send(8'h00, s);
    for (int i = 0; i < 5; i++) bit_clk(1'b0, s);
    stop_c();
    chk_fields("R10 stop mid byte");
    // R10 / R11 abort by repeated START, then complete write
    start_c(); send(8'hC0, s); send(8'h01, s);
    for (int i = 0; i < 3; i++) bit_clk(1'b1, s);
    start_c(); send(8'hC0, s); send(8'h01, s); send(8'h33, s); stop_c();
    model_wr(8'h01, 8'h33);
    chk_fields("R11 write after aborting start");

    // R8 disabled target
    en_tb = 1'b0; half();
    do_write(8'h00, 8'h11, ak);
    chk(ak == 3'b000, "R8 no ack while disabled", ak, 0);
    chk_fields("R8 registers held while disabled");

    // R9 enable rising edge reloads defaults
    do_write(8'h00, 8'h00, ak);
    en_tb = 1'b1; half();
    m0 = 8'h2D; m1 = 8'h17;
    chk_fields("R9 defaults after enable rise");

    // random traffic against the model
    for (int n = 0; n < 60; n++) begin
      logic [7:0] a, d;
      a = 8'($urandom_range(0, 3));
      d = 8'($urandom);
      pg = 1'($urandom);
      if ($urandom_range(0, 1) == 0) begin
        do_write(a, d, ak);
        model_wr(a, d);
        chk(ak == 3'b111, "R3 random write acks", ak, 3'b111);
        chk_fields("R4 random write fields");
      end else begin
        do_read(a, rd, ak);
        chk(rd == exp_rd(a, pg), "R5 random read", rd, exp_rd(a, pg));
      end
      if (n == 30) begin
        en_tb = 1'b0; half(); en_tb = 1'b1; half();
        m0 = 8'h2D; m1 = 8'h17;
        chk_fields("R9 random enable pulse");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule